// File: doc/BRIEF.md
# Paired-Channel Compare Output Unit

This block holds sixteen compare channels that all watch one shared timer count. When the count equals a channel's compare value on a count-update strobe, the channel raises a one-cycle interrupt request. Depending on its mode, the channel can also drive an output latch. In set/clear mode a match sets the latch and a timer overflow clears it. Software can preset or overwrite any latch at any time, and a software write wins over a hardware change in the same cycle. A per-pin direction bit gates each latch onto its pin.

Channels 0 to 7 form the lower bank and channels 8 to 15 form the upper bank. Channel n and channel n+8 become a pair when both are given the paired mode code. The pair then shares the pin of channel n. A match on either register toggles that pin's latch, and the latch of channel n+8 is left to software.

Each channel runs a small arming machine with two states. The machine starts in ST_ARMED after reset. A match moves it from ST_ARMED to ST_SPENT. An overflow moves it from ST_SPENT back to ST_ARMED. A match in the same cycle as an overflow is allowed, belongs to the new timer period, and leaves the machine in ST_SPENT. Each latch takes one action per cycle: ACT_HOLD, ACT_SET, ACT_CLR or ACT_TOG.

Top module: `cmp_out_unit`

## Requirements
- R1: After reset every pin output and every interrupt request is 0, and every channel is in mode 00.
- R2: Mode code 10 (set/clear) works as follows. A match sets the channel's latch on the clock edge that samples it, and a timer overflow pulse clears the latch.
- R3: When sw_we[i] is 1, latch i takes sw_val[i] on that edge, and any hardware set, clear or toggle in the same cycle is dropped.
- R4: In set/clear mode, when a channel's compare value equals tmr_reload, a match still raises its interrupt request, but neither a match nor an overflow changes its latch.
- R5: A match in mode 01, 10 or 11 drives irq[i] high for exactly the one cycle after the edge that samples it. A channel in mode 00 never raises irq[i].
- R6: A channel matches at most once per timer period. If its compare value is rewritten after it has matched, the new value can match only after the next overflow pulse.
- R7: pin_out[i] equals latch i when dir[i] is 1, and pin_out[i] is 0 when dir[i] is 0.
- R8: When channel n (n < 8) and channel n+8 both hold mode 11, the pair works as follows:
  - a match on either channel inverts latch n;
  - matches on both channels in the same cycle invert latch n only once;
  - an overflow does not clear latch n;
  - hardware never changes latch n+8.
- R9: A channel in mode 11 whose partner is not in mode 11 behaves exactly as in mode 10.
- R10: Mode code 01 raises interrupt requests only and never changes the latch.
- R11: No match occurs while tmr_strobe is 0, even if the count equals the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_count | input | 16 | Shared timer count |
| tmr_strobe | input | 1 | Count-update strobe; a match is checked only when this is 1 |
| tmr_ovf | input | 1 | Timer overflow pulse |
| tmr_reload | input | 16 | Timer reload value |
| cmp_we | input | 1 | Compare register write enable |
| cmp_idx | input | 4 | Channel selected for a compare write |
| cmp_wdata | input | 16 | New compare value |
| mode_we | input | 1 | Mode field write enable |
| mode_idx | input | 4 | Channel selected for a mode write |
| mode_wdata | input | 2 | New mode code (00 off, 01 irq only, 10 set/clear, 11 paired) |
| sw_we | input | 16 | Per-latch software write strobes |
| sw_val | input | 16 | Per-latch software write values |
| dir | input | 16 | Per-pin direction bits; 1 drives the latch onto the pin |
| irq | output | 16 | Per-channel interrupt request pulses |
| pin_out | output | 16 | Compare output pins |

## Verification
Two events can land on one latch edge in the same cycle, and each such clash is provoked directly. A software write can meet a compare match on the same edge; the pin must then show the software value while the interrupt still fires. The two members of a pair can match in the same cycle; the shared pin must change only once while both interrupt requests pulse. A third clash is also covered: a match landing on a channel that has already matched in the current period, before and after a compare rewrite. Here the interrupt output must stay low until an overflow has re-armed the channel.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_IRQ    = 2'b01,
        MODE_SETCLR = 2'b10,
        MODE_PAIR   = 2'b11
    } cmp_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_TOG  = 2'b11
    } latch_act_e;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_SPENT = 1'b1
    } arm_state_e;

endpackage

// File: rtl/cmp_chan_fsm.sv
module cmp_chan_fsm
    import cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tmr_count,
    input  logic             tmr_strobe,
    input  logic             tmr_ovf,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             mode_we,
    input  logic [1:0]       mode_wdata,
    output cmp_mode_e        mode_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             hit_o,
    output logic             irq_o
);

    arm_state_e       state_q, state_d;
    cmp_mode_e        mode_q;
    logic [CNT_W-1:0] cmp_q;
    logic             irq_q;
    logic             hit;

    // A match is possible while armed, or on the overflow cycle that opens a new period
    always_comb begin
        hit = (mode_q != MODE_OFF) && tmr_strobe && (tmr_count == cmp_q)
              && ((state_q == ST_ARMED) || tmr_ovf);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: state_d = hit ? ST_SPENT : ST_ARMED;
            ST_SPENT: begin
                if (hit)          state_d = ST_SPENT;
                else if (tmr_ovf) state_d = ST_ARMED;
                else              state_d = ST_SPENT;
            end
            default:  state_d = ST_ARMED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // Register file and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            mode_q <= MODE_OFF;
            irq_q  <= 1'b0;
        end else begin
            if (cmp_we)  cmp_q  <= cmp_wdata;
            if (mode_we) mode_q <= cmp_mode_e'(mode_wdata);
            irq_q <= hit;
        end
    end

    assign mode_o = mode_q;
    assign cmp_o  = cmp_q;
    assign hit_o  = hit;
    assign irq_o  = irq_q;

    a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPENT && !tmr_ovf) |-> !hit);
    a_r5_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> irq_o);
    a_r5_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !irq_o);
    a_r11_strobe_needed: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_strobe |-> !hit);

endmodule

// File: rtl/cmp_pair_ctl.sv
module cmp_pair_ctl
    import cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  cmp_mode_e        mode_lo,
    input  cmp_mode_e        mode_hi,
    input  logic             hit_lo,
    input  logic             hit_hi,
    input  logic [CNT_W-1:0] cmp_lo,
    input  logic [CNT_W-1:0] cmp_hi,
    input  logic [CNT_W-1:0] tmr_reload,
    input  logic             tmr_ovf,
    output logic             paired_o,
    output latch_act_e       act_lo,
    output latch_act_e       act_hi
);

    function automatic latch_act_e single_act(input cmp_mode_e m, input logic hit,
                                              input logic eq, input logic ovf);
        latch_act_e a;
        a = ACT_HOLD;
        if ((m == MODE_SETCLR || m == MODE_PAIR) && !eq) begin
            if (hit)      a = ACT_SET;
            else if (ovf) a = ACT_CLR;
        end
        return a;
    endfunction

    logic paired;
    logic eq_lo, eq_hi;

    always_comb begin
        paired = (mode_lo == MODE_PAIR) && (mode_hi == MODE_PAIR);
        eq_lo  = (cmp_lo == tmr_reload);
        eq_hi  = (cmp_hi == tmr_reload);
        if (paired) begin
            act_lo = (hit_lo || hit_hi) ? ACT_TOG : ACT_HOLD;
            act_hi = ACT_HOLD;
        end else begin
            act_lo = single_act(mode_lo, hit_lo, eq_lo, tmr_ovf);
            act_hi = single_act(mode_hi, hit_hi, eq_hi, tmr_ovf);
        end
    end

    assign paired_o = paired;

endmodule

// File: rtl/cmp_pin_latch.sv
module cmp_pin_latch
    import cmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  latch_act_e act,
    input  logic       sw_we,
    input  logic       sw_val,
    input  logic       dir,
    output logic       pin_o
);

    logic latch_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
        end else if (sw_we) begin
            latch_q <= sw_val;
        end else begin
            unique case (act)
                ACT_HOLD: latch_q <= latch_q;
                ACT_SET:  latch_q <= 1'b1;
                ACT_CLR:  latch_q <= 1'b0;
                ACT_TOG:  latch_q <= ~latch_q;
                default:  latch_q <= latch_q;
            endcase
        end
    end

    assign pin_o = dir & latch_q;

    a_r3_sw_priority: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (latch_q == $past(sw_val)));
    a_r2_set_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && act == ACT_SET) |=> latch_q);
    a_r2_clear_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && act == ACT_CLR) |=> !latch_q);
    a_r8_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && act == ACT_TOG) |=> (latch_q != $past(latch_q)));

endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
    import cmp_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CNT_W  = 16,
    localparam int NPAIR = NUM_CH / 2,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  tmr_count,
    input  logic              tmr_strobe,
    input  logic              tmr_ovf,
    input  logic [CNT_W-1:0]  tmr_reload,
    input  logic              cmp_we,
    input  logic [IDX_W-1:0]  cmp_idx,
    input  logic [CNT_W-1:0]  cmp_wdata,
    input  logic              mode_we,
    input  logic [IDX_W-1:0]  mode_idx,
    input  logic [1:0]        mode_wdata,
    input  logic [NUM_CH-1:0] sw_we,
    input  logic [NUM_CH-1:0] sw_val,
    input  logic [NUM_CH-1:0] dir,
    output logic [NUM_CH-1:0] irq,
    output logic [NUM_CH-1:0] pin_out
);

    cmp_mode_e        mode   [NUM_CH];
    logic [CNT_W-1:0] cmpv   [NUM_CH];
    logic             hit    [NUM_CH];
    latch_act_e       act    [NUM_CH];
    logic             paired [NPAIR];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        cmp_chan_fsm #(.CNT_W(CNT_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .tmr_count  (tmr_count),
            .tmr_strobe (tmr_strobe),
            .tmr_ovf    (tmr_ovf),
            .cmp_we     (cmp_we && (cmp_idx == IDX_W'(i))),
            .cmp_wdata  (cmp_wdata),
            .mode_we    (mode_we && (mode_idx == IDX_W'(i))),
            .mode_wdata (mode_wdata),
            .mode_o     (mode[i]),
            .cmp_o      (cmpv[i]),
            .hit_o      (hit[i]),
            .irq_o      (irq[i])
        );

        cmp_pin_latch u_latch (
            .clk    (clk),
            .rst_n  (rst_n),
            .act    (act[i]),
            .sw_we  (sw_we[i]),
            .sw_val (sw_val[i]),
            .dir    (dir[i]),
            .pin_o  (pin_out[i])
        );
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        cmp_pair_ctl #(.CNT_W(CNT_W)) u_pair (
            .mode_lo    (mode[p]),
            .mode_hi    (mode[p+NPAIR]),
            .hit_lo     (hit[p]),
            .hit_hi     (hit[p+NPAIR]),
            .cmp_lo     (cmpv[p]),
            .cmp_hi     (cmpv[p+NPAIR]),
            .tmr_reload (tmr_reload),
            .tmr_ovf    (tmr_ovf),
            .paired_o   (paired[p]),
            .act_lo     (act[p]),
            .act_hi     (act[p+NPAIR])
        );

        a_r8_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
            paired[p] |-> (act[p+NPAIR] == ACT_HOLD));
        a_r8_no_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (paired[p] && tmr_ovf) |-> (act[p] != ACT_CLR));
    end

endmodule

// File: tb/cmp_out_unit_tb_top.sv
`timescale 1ns/1ps
module cmp_out_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] tmr_count, tmr_reload, cmp_wdata;
    logic        tmr_strobe, tmr_ovf, cmp_we, mode_we;
    logic [3:0]  cmp_idx, mode_idx;
    logic [1:0]  mode_wdata;
    logic [15:0] sw_we, sw_val, dir, irq, pin_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cmp_out_unit dut_i (
        .clk(clk), .rst_n(rst_n), .tmr_count(tmr_count), .tmr_strobe(tmr_strobe),
        .tmr_ovf(tmr_ovf), .tmr_reload(tmr_reload), .cmp_we(cmp_we), .cmp_idx(cmp_idx),
        .cmp_wdata(cmp_wdata), .mode_we(mode_we), .mode_idx(mode_idx),
        .mode_wdata(mode_wdata), .sw_we(sw_we), .sw_val(sw_val), .dir(dir),
        .irq(irq), .pin_out(pin_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_cmp(input int idx, input int val);
        cmp_idx = 4'(idx); cmp_wdata = 16'(val); cmp_we = 1'b1;
        @(negedge clk); cmp_we = 1'b0;
    endtask

    task automatic wr_mode(input int idx, input logic [1:0] m);
        mode_idx = 4'(idx); mode_wdata = m; mode_we = 1'b1;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic strobe(input int cnt);
        tmr_count = 16'(cnt); tmr_strobe = 1'b1;
        @(negedge clk); tmr_strobe = 1'b0;
    endtask

    task automatic ovf();
        tmr_ovf = 1'b1;
        @(negedge clk); tmr_ovf = 1'b0;
    endtask

    task automatic sw(input int idx, input logic v);
        sw_we[idx] = 1'b1; sw_val[idx] = v;
        @(negedge clk); sw_we[idx] = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 pins", 32'(pin_out), 0);
        chk("R1 irq", 32'(irq), 0);
        strobe(0);
        chk("R1 modes off, no irq at count 0", 32'(irq), 0);
    endtask

    task automatic t_setclr();
        wr_mode(0, 2'b10); wr_cmp(0, 100);
        strobe(100);
        chk("R2 set pin0", 32'(pin_out[0]), 1);
        chk("R5 irq0 pulse", 32'(irq[0]), 1);
        @(negedge clk);
        chk("R5 irq0 one cycle", 32'(irq[0]), 0);
        dir[0] = 1'b0; #0.1;
        chk("R7 dir off", 32'(pin_out[0]), 0);
        dir[0] = 1'b1; #0.1;
        chk("R7 dir on", 32'(pin_out[0]), 1);
        ovf();
        chk("R2 clear on ovf", 32'(pin_out[0]), 0);
    endtask

    task automatic t_nostrobe();
        tmr_count = 16'd100; @(negedge clk);
        chk("R11 no strobe no irq", 32'(irq[0]), 0);
        chk("R11 no strobe pin", 32'(pin_out[0]), 0);
    endtask

    task automatic t_reload_eq();
        wr_mode(1, 2'b10); wr_cmp(1, 50); tmr_reload = 16'd50;
        strobe(50);
        chk("R4 irq still fires", 32'(irq[1]), 1);
        chk("R4 pin unchanged on match", 32'(pin_out[1]), 0);
        sw(1, 1'b1);
        ovf();
        chk("R4 pin unchanged on ovf", 32'(pin_out[1]), 1);
        sw(1, 1'b0);
        tmr_reload = 16'd0;
    endtask

    task automatic t_sw_prio();
        wr_mode(2, 2'b10); wr_cmp(2, 20);
        sw_we[2] = 1'b1; sw_val[2] = 1'b0;
        strobe(20);
        sw_we[2] = 1'b0;
        chk("R3 sw wins over set", 32'(pin_out[2]), 0);
        chk("R3 irq still raised", 32'(irq[2]), 1);
    endtask

    task automatic t_once();
        wr_mode(3, 2'b10); wr_cmp(3, 30);
        strobe(30);
        chk("R6 first match", 32'(irq[3]), 1);
        sw(3, 1'b0);
        strobe(30);
        chk("R6 second match blocked irq", 32'(irq[3]), 0);
        chk("R6 second match blocked pin", 32'(pin_out[3]), 0);
        wr_cmp(3, 40);
        strobe(40);
        chk("R6 rewrite waits for period", 32'(irq[3]), 0);
        ovf();
        strobe(40);
        chk("R6 new value after ovf irq", 32'(irq[3]), 1);
        chk("R6 new value after ovf pin", 32'(pin_out[3]), 1);
    endtask

    task automatic t_irqonly();
        wr_mode(4, 2'b01); wr_cmp(4, 10);
        wr_mode(5, 2'b00); wr_cmp(5, 10);
        strobe(10);
        chk("R10 irq only fires", 32'(irq[4]), 1);
        chk("R10 latch untouched", 32'(pin_out[4]), 0);
        chk("R5 mode 00 silent", 32'(irq[5]), 0);
    endtask

    task automatic t_lone();
        ovf();
        wr_mode(6, 2'b11); wr_cmp(6, 70);
        strobe(70);
        chk("R9 lone 11 sets", 32'(pin_out[6]), 1);
        ovf();
        chk("R9 lone 11 clears", 32'(pin_out[6]), 0);
    endtask

    task automatic t_pair();
        wr_mode(7, 2'b11); wr_mode(15, 2'b11);
        wr_cmp(7, 200); wr_cmp(15, 300);
        ovf();
        strobe(200);
        chk("R8 lower match toggles", 32'(pin_out[7]), 1);
        chk("R8 irq7", 32'(irq[7]), 1);
        strobe(300);
        chk("R8 upper match toggles", 32'(pin_out[7]), 0);
        chk("R8 irq15", 32'(irq[15]), 1);
        chk("R8 upper latch untouched", 32'(pin_out[15]), 0);
        sw(7, 1'b1);
        ovf();
        chk("R8 ovf does not clear", 32'(pin_out[7]), 1);
        wr_cmp(15, 200);
        strobe(200);
        chk("R8 double match single toggle", 32'(pin_out[7]), 0);
        chk("R8 both irqs", 32'({irq[15], irq[7]}), 3);
    endtask

    initial begin
        rst_n = 1'b0; tmr_count = '0; tmr_strobe = 1'b0; tmr_ovf = 1'b0;
        tmr_reload = '0; cmp_we = 1'b0; cmp_idx = '0; cmp_wdata = '0;
        mode_we = 1'b0; mode_idx = '0; mode_wdata = '0;
        sw_we = '0; sw_val = '0; dir = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setclr();
        t_nostrobe();
        t_reload_eq();
        t_sw_prio();
        t_once();
        t_irqonly();
        t_lone();
        t_pair();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule